// File: doc/BRIEF.md
# Hybrid PRG/CHR Bank Mapper

This block is the address decoder of a game cartridge that sits on two buses: an 8-bit CPU bus and a picture-processor (PPU) bus. It holds one write-only bank register. The CPU loads that register by writing anywhere in the lower half of its cartridge space. The register supplies a 2-bit program-ROM bank and a 4-bit character-RAM bank.

On the CPU side, a 64 KiB program ROM is seen through two 16 KiB windows. The first window is switchable. The second window always shows the last bank. On the PPU side, 64 KiB of character RAM is built from two 32 KiB SRAMs. It is seen through two 4 KiB windows. The lower window is fixed to physical bank 0, which sits in the first SRAM; that SRAM is the volatile one. The upper window is switchable.

By default the switchable bank is decoded by inversion, so the physical bank is the bitwise complement of the value written. The low bank bits also reach the SRAM address lines in reversed order. A parameter selects plain decoding instead. Software cannot see either choice, because the RAM is only reachable through this decoder. All outputs are combinational from the bus inputs and the register. There is no back-pressure: the address is valid in the same cycle, and there is no valid/ready handshake because nothing is streamed.

Top module: `hbank_mapper`

## Requirements
- R1: After reset the register holds zero: CPU $8000-$BFFF reads PRG bank 0, and with inverted decoding the PPU upper window maps to physical bank 15.
- R2: A CPU write with cpu_addr[15:14]=2'b10 loads the PRG bank from cpu_wdata[7:6] and the CHR bank from cpu_wdata[3:0], taken on the next rising clock; cpu_wdata[5:4] have no effect.
- R3: CPU writes with cpu_addr[15:14] other than 2'b10 leave both banks unchanged.
- R4: For cpu_addr[15:14]=2'b10, prg_ce is 1 and prg_addr = {PRG bank, cpu_addr[13:0]}.
- R5: For cpu_addr[15:14]=2'b11, prg_ce is 1 and prg_addr = {2'b11, cpu_addr[13:0]}, whatever the register holds.
- R6: For cpu_addr[15]=0, prg_ce is 0.
- R7: With INVERT_CHR=1, a PPU access with ppu_addr[12]=1 uses physical bank = bitwise complement of the written CHR value (7 gives 8, 0 gives 15, 8 gives 7).
- R8: A PPU access with ppu_addr[13:12]=2'b00 uses physical bank 0 whatever the register holds, so it always selects the first SRAM.
- R9: During a PPU read or write with ppu_addr[13]=0, sram_cs is 2'b01 for physical banks 0-7 and 2'b10 for banks 8-15. Otherwise sram_cs is 2'b00.
- R10: chr_addr[11:0] = ppu_addr[11:0] and chr_addr[14:12] = {p[0], p[1], p[2]}, where p is the physical bank.
- R11: chr_we is 1 only when ppu_wr is 1 and ppu_addr[13]=0.
- R12: With INVERT_CHR=0, the physical bank for the upper window equals the written CHR value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_wr | input | 1 | PPU write strobe |
| prg_ce | output | 1 | Program ROM enable |
| prg_addr | output | 16 | Program ROM address |
| chr_addr | output | 15 | Address inside the selected SRAM |
| sram_cs | output | 2 | One-hot SRAM selects, bit 0 the volatile chip |
| chr_we | output | 1 | SRAM write enable |

## Verification
The register is loaded with values chosen to tell the rules apart. Bits 5:4 are set while the fields are loaded, so a decoder that picks the wrong slice is caught. A CHR value of 1 separates reversed from straight address bits, because straight order gives a different chip address. The values 0, 7 and 8 sit on both sides of the chip boundary, and under inversion each one lands in the other SRAM. Writes above $BFFF and below $8000 test that only the switchable window loads the register.

A second instance with plain decoding gets the same stimulus. This shows that the inversion is the only difference between the two. PPU accesses above $1FFF and idle PPU cycles test the selects and the write enable.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    CPU_SPACE_LOW  = 2'd0,
    CPU_SPACE_SWAP = 2'd1,
    CPU_SPACE_LAST = 2'd2
  } cpu_space_e;

  function automatic cpu_space_e cpu_space(input logic [1:0] top_bits);
    case (top_bits)
      2'b10:   return CPU_SPACE_SWAP;
      2'b11:   return CPU_SPACE_LAST;
      default: return CPU_SPACE_LOW;
    endcase
  endfunction

endpackage

// File: rtl/hbm_bank_reg.sv
module hbm_bank_reg #(
  parameter int PRG_BANK_W = 2,
  parameter int CHR_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [PRG_BANK_W-1:0] prg_in,
  input  logic [CHR_BANK_W-1:0] chr_in,
  output logic [PRG_BANK_W-1:0] prg_bank,
  output logic [CHR_BANK_W-1:0] chr_bank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank <= '0;
      chr_bank <= '0;
    end else if (load) begin
      prg_bank <= prg_in;
      chr_bank <= chr_in;
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prg_bank == $past(prg_in)) && (chr_bank == $past(chr_in)));

  // R3
  no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prg_bank) && $stable(chr_bank));

endmodule

// File: rtl/hbm_prg_map.sv
module hbm_prg_map
  import hbm_pkg::*;
#(
  parameter int PRG_BANK_W = 2,
  parameter int PRG_WIN_W  = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PRG_BANK_W+PRG_WIN_W-1:0] cpu_addr,
  input  logic [PRG_BANK_W-1:0]          prg_bank,
  output logic                           prg_ce,
  output logic [PRG_BANK_W+PRG_WIN_W-1:0] prg_addr
);

  localparam int ADDR_W = PRG_BANK_W + PRG_WIN_W;
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

  cpu_space_e space;
  logic [PRG_BANK_W-1:0] bank_mux;

  always_comb begin
    space = cpu_space(cpu_addr[ADDR_W-1 -: 2]);
    case (space)
      CPU_SPACE_SWAP: bank_mux = prg_bank;
      CPU_SPACE_LAST: bank_mux = LAST_BANK;
      default:        bank_mux = prg_bank;
    endcase
    prg_ce   = (space != CPU_SPACE_LOW);
    prg_addr = {bank_mux, cpu_addr[PRG_WIN_W-1:0]};
  end

  // R5
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] == 2'b11) |-> (prg_addr[ADDR_W-1 -: PRG_BANK_W] == LAST_BANK));

  // R6
  low_space_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> !prg_ce);

endmodule

// File: rtl/hbm_chr_map.sv
module hbm_chr_map #(
  parameter int CHR_BANK_W   = 4,
  parameter int CHR_WIN_W    = 12,
  parameter bit INVERT_CHR   = 1'b1,
  parameter bit SCRAMBLE_CHR = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CHR_WIN_W+1:0]          ppu_addr,
  input  logic                          ppu_rd,
  input  logic                          ppu_wr,
  input  logic [CHR_BANK_W-1:0]         chr_bank,
  output logic [CHR_WIN_W+CHR_BANK_W-2:0] chr_addr,
  output logic [1:0]                    sram_cs,
  output logic                          chr_we
);

  localparam int LOW_W = CHR_BANK_W - 1;

  logic [CHR_BANK_W-1:0] phys;
  logic [LOW_W-1:0]      chip_hi;
  logic                  in_pattern;
  logic                  upper_win;
  logic                  active;

  assign in_pattern = !ppu_addr[CHR_WIN_W+1];
  assign upper_win  = ppu_addr[CHR_WIN_W];
  assign active     = in_pattern && (ppu_rd || ppu_wr);

  generate
    if (INVERT_CHR) begin : g_inv
      assign phys = upper_win ? ~chr_bank : '0;
    end else begin : g_plain
      assign phys = upper_win ? chr_bank : '0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < LOW_W; i++) begin : g_line
      if (SCRAMBLE_CHR) begin : g_rev
        assign chip_hi[i] = phys[LOW_W-1-i];
      end else begin : g_str
        assign chip_hi[i] = phys[i];
      end
    end
  endgenerate

  assign chr_addr   = {chip_hi, ppu_addr[CHR_WIN_W-1:0]};
  assign sram_cs[0] = active && !phys[CHR_BANK_W-1];
  assign sram_cs[1] = active &&  phys[CHR_BANK_W-1];
  assign chr_we     = ppu_wr && in_pattern;

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sram_cs) && ((sram_cs != 2'b00) == active));

  // R8
  lower_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !upper_win) |-> (sram_cs == 2'b01));

  // R11
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> (ppu_wr && !ppu_addr[CHR_WIN_W+1]));

endmodule

// File: rtl/hbank_mapper.sv
module hbank_mapper
  import hbm_pkg::*;
#(
  parameter int PRG_BANK_W   = 2,
  parameter int PRG_WIN_W    = 14,
  parameter int CHR_BANK_W   = 4,
  parameter int CHR_WIN_W    = 12,
  parameter int DATA_W       = 8,
  parameter bit INVERT_CHR   = 1'b1,
  parameter bit SCRAMBLE_CHR = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [PRG_BANK_W+PRG_WIN_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  input  logic                               cpu_we,
  input  logic [CHR_WIN_W+1:0]               ppu_addr,
  input  logic                               ppu_rd,
  input  logic                               ppu_wr,
  output logic                               prg_ce,
  output logic [PRG_BANK_W+PRG_WIN_W-1:0]    prg_addr,
  output logic [CHR_WIN_W+CHR_BANK_W-2:0]    chr_addr,
  output logic [1:0]                         sram_cs,
  output logic                               chr_we
);

  localparam int CPU_W     = PRG_BANK_W + PRG_WIN_W;
  localparam int GAP_W     = DATA_W - PRG_BANK_W - CHR_BANK_W;

  logic                  load;
  logic [PRG_BANK_W-1:0] prg_bank;
  logic [CHR_BANK_W-1:0] chr_bank;
  logic                  unused_gap;

  assign load       = cpu_we && (cpu_space(cpu_addr[CPU_W-1 -: 2]) == CPU_SPACE_SWAP);
  assign unused_gap = ^cpu_wdata[CHR_BANK_W +: GAP_W];

  hbm_bank_reg #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .prg_in   (cpu_wdata[DATA_W-1 -: PRG_BANK_W]),
    .chr_in   (cpu_wdata[CHR_BANK_W-1:0]),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank)
  );

  hbm_prg_map #(
    .PRG_BANK_W(PRG_BANK_W),
    .PRG_WIN_W (PRG_WIN_W)
  ) u_prg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .prg_bank (prg_bank),
    .prg_ce   (prg_ce),
    .prg_addr (prg_addr)
  );

  hbm_chr_map #(
    .CHR_BANK_W  (CHR_BANK_W),
    .CHR_WIN_W   (CHR_WIN_W),
    .INVERT_CHR  (INVERT_CHR),
    .SCRAMBLE_CHR(SCRAMBLE_CHR)
  ) u_chr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ppu_addr (ppu_addr),
    .ppu_rd   (ppu_rd),
    .ppu_wr   (ppu_wr),
    .chr_bank (chr_bank),
    .chr_addr (chr_addr),
    .sram_cs  (sram_cs),
    .chr_we   (chr_we)
  );

  // R4
  swap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_W-1 -: 2] == 2'b10) |-> (prg_ce && prg_addr[PRG_WIN_W-1:0] == cpu_addr[PRG_WIN_W-1:0]));

endmodule

// File: tb/hbank_mapper_test.sv
module hbank_mapper_test;

  typedef struct {
    string       tag;
    logic        ce;
    logic [15:0] prg;
    logic [14:0] chr;
    logic [1:0]  cs;
    logic        we;
    logic [14:0] chr_p;
    logic [1:0]  cs_p;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0, ppu_wr = 1'b0;
  logic        prg_ce, chr_we, chr_we_p, prg_ce_p;
  logic [15:0] prg_addr, prg_addr_p;
  logic [14:0] chr_addr, chr_addr_p;
  logic [1:0]  sram_cs, sram_cs_p;

  int checks = 0, fails = 0;
  logic [1:0] m_prg = 2'd0;
  logic [3:0] m_chr = 4'd0;
  item_t q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .prg_ce(prg_ce),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .sram_cs(sram_cs), .chr_we(chr_we));

  hbank_mapper #(.INVERT_CHR(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .prg_ce(prg_ce_p),
    .prg_addr(prg_addr_p), .chr_addr(chr_addr_p), .sram_cs(sram_cs_p), .chr_we(chr_we_p));

  function automatic logic [3:0] phys_bank(input logic [13:0] pa, input logic [3:0] v, input bit inv);
    if (!pa[12]) return 4'd0;
    return inv ? (4'd15 - v) : v;
  endfunction

  function automatic logic [14:0] chip_addr(input logic [3:0] p, input logic [13:0] pa);
    return {p[0], p[1], p[2], pa[11:0]};
  endfunction

  function automatic logic [1:0] chip_sel(input logic [3:0] p, input logic [13:0] pa, input logic rd, input logic wr);
    if (pa[13] || !(rd || wr)) return 2'b00;
    return (p >= 4'd8) ? 2'b10 : 2'b01;
  endfunction

  task automatic probe(input string tag, input logic [15:0] ca, input logic [13:0] pa,
                       input logic rd, input logic wr);
    item_t it;
    logic [3:0] pi, pp;
    @(negedge clk);
    cpu_addr = ca; ppu_addr = pa; ppu_rd = rd; ppu_wr = wr; cpu_we = 1'b0;
    pi = phys_bank(pa, m_chr, 1'b1);
    pp = phys_bank(pa, m_chr, 1'b0);
    it.tag   = tag;
    it.ce    = ca[15];
    it.prg   = {(ca[14] ? 2'b11 : m_prg), ca[13:0]};
    it.chr   = chip_addr(pi, pa);
    it.cs    = chip_sel(pi, pa, rd, wr);
    it.we    = wr && !pa[13];
    it.chr_p = chip_addr(pp, pa);
    it.cs_p  = chip_sel(pp, pa, rd, wr);
    q.push_back(it);
    @(posedge clk);
    #3;
  endtask

  task automatic write_reg(input logic [15:0] ca, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = ca; cpu_wdata = d; cpu_we = 1'b1; ppu_rd = 1'b0; ppu_wr = 1'b0;
    @(posedge clk);
    if (ca[15:14] == 2'b10) begin
      m_prg = d[7:6];
      m_chr = d[3:0];
    end
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (prg_ce !== e.ce || (e.ce && prg_addr !== e.prg) || chr_addr !== e.chr ||
            sram_cs !== e.cs || chr_we !== e.we || chr_addr_p !== e.chr_p || sram_cs_p !== e.cs_p) begin
          fails++;
          $display("FAIL %s: actual ce=%b prg=%h chr=%h cs=%b we=%b plain chr=%h cs=%b expected ce=%b prg=%h chr=%h cs=%b we=%b plain chr=%h cs=%b",
                   e.tag, prg_ce, prg_addr, chr_addr, sram_cs, chr_we, chr_addr_p, sram_cs_p,
                   e.ce, e.prg, e.chr, e.cs, e.we, e.chr_p, e.cs_p);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    probe("R1 reset state", 16'h8123, 14'h1456, 1'b1, 1'b0);
    write_reg(16'h8000, 8'b0111_0111);
    probe("R2 R4 load prg 1 chr 7, bits 5:4 set", 16'h9ABC, 14'h1ABC, 1'b1, 1'b0);
    probe("R7 R12 upper window chr 7 write", 16'hA000, 14'h1FFF, 1'b0, 1'b1);
    write_reg(16'hBFFF, 8'b1000_0001);
    probe("R10 reversed bits chr 1", 16'hBFFF, 14'h1234, 1'b1, 1'b0);
    write_reg(16'hC000, 8'hFF);
    probe("R3 write at C000 ignored", 16'h8001, 14'h1001, 1'b1, 1'b0);
    write_reg(16'h6000, 8'h00);
    probe("R3 write at 6000 ignored", 16'hB555, 14'h1555, 1'b1, 1'b0);
    probe("R5 fixed last bank", 16'hF00F, 14'h0000, 1'b0, 1'b0);
    probe("R6 low cpu space off", 16'h4020, 14'h0000, 1'b0, 1'b0);
    probe("R8 R11 lower window write", 16'h8000, 14'h0123, 1'b0, 1'b1);
    probe("R9 R11 write above pattern space", 16'hC000, 14'h2005, 1'b0, 1'b1);
    probe("R9 idle ppu", 16'hC000, 14'h1005, 1'b0, 1'b0);
    write_reg(16'h8000, 8'b1100_0000);
    probe("R7 R9 chr 0 to bank 15", 16'h8800, 14'h1800, 1'b1, 1'b0);
    write_reg(16'h8000, 8'b0000_1000);
    probe("R7 R9 chr 8 to bank 7", 16'h8800, 14'h1800, 1'b0, 1'b1);
    probe("R8 lower window fixed", 16'h8800, 14'h0FFF, 1'b1, 1'b0);
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule